// File: doc/BRIEF.md
# Parallel Port Extended Control Register Bank with Test FIFO

This block is the extended register bank of a parallel port. It sits on a byte-wide register bus with a 3-bit offset and holds three registers. The extended control register selects the port's operating mode and reports the state of a small data FIFO. Configuration register B is a plain byte of storage. The offset-0 slot has two meanings. In FIFO-test mode it is the FIFO's data port: writes push and reads pop. In every other mode it is a configuration register whose bits 6:4 report the FIFO word width.

Changing the mode field flushes the FIFO, so the buffer is only reachable while FIFO-test mode is held. The empty and full conditions are encoded in the two low bits of the control register and are also brought out as pins. The block does not implement cable-side transfers or the data paths of the other modes.

Top module: `lpt_ecr_bank`

## Requirements
- R1: After reset the control register (offset 2) reads 0x01 (mode 0, empty flag set), offset 0 reads 0x10 and offset 1 reads 0x00.
- R2: Control register bits 7:5 hold the mode (0 compatibility, 1 byte, 2 PP FIFO, 3 ECP FIFO, 4 EPP, 5 reserved, 6 FIFO test, 7 configuration). A write to offset 2 replaces the mode field and bits 4:2 with the written values. Bits 1:0 are read-only status.
- R3: A write to offset 2 whose bits 7:5 differ from the current mode resets both FIFO pointers, sets empty (bit 0) and clears full (bit 1). A write that keeps the same mode leaves the FIFO and its flags untouched.
- R4: In mode 6, a write to offset 0 stores the byte at the write pointer and advances it. When the pointer reaches the depth (2), the full flag is set, empty is cleared and the pointer returns to 0. Otherwise both flags are cleared.
- R5: In mode 6, a read of offset 0 returns the byte at the read pointer, then advances that pointer modulo the depth. If the pointers are then equal, empty is set and full is cleared. Otherwise both flags are cleared.
- R6: Outside mode 6, offset 0 is a plain read/write byte and does not touch the FIFO. Its reset value carries the width code 1 (8-bit) in bits 6:4; code 0 means 16-bit and code 2 means 32-bit.
- R7: Offset 1 is a plain read/write byte.
- R8: Reads of offsets 3 to 7 return 0xFF, and writes to those offsets change no state.
- R9: The empty and full flags are never set together. The `fifo_empty` and `fifo_full` pins always equal control register bits 0 and 1.
- R10: A push while the full flag is set is not refused. It overwrites the slot at the wrapped write pointer and follows the R4 flag rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one access per cycle |
| rd_en | input | 1 | Register read strobe; ignored when wr_en is high |
| addr | input | 3 | Register offset within the bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed offset, from current state |
| fifo_empty | output | 1 | FIFO empty flag |
| fifo_full | output | 1 | FIFO full flag |
| mode | output | 3 | Current mode field |

## Verification
Directed sequences come first.
- **Mode sweep.** All eight mode codes are written and read back. This separates field replacement from OR-merging and shows that the low status bits are read-only.
- **FIFO fill and drain.** The FIFO is filled to full and drained back to empty. An extra push past full shows the overwrite and wrap rule. Same-mode and new-mode control writes made with data buffered separate a flush from a no-op.

A long pseudo-random stream of mixed reads and writes over all eight offsets follows, weighted toward FIFO-test mode. A bench-side model of the registers and pointers checks every read value and both flag pins after each access. This catches pointer-wrap and flag-update mismatches that the directed cases do not reach.

// File: rtl/lpt_ecr_pkg.sv
package lpt_ecr_pkg;

    localparam int BYTE_W  = 8;
    localparam int OFS_W   = 3;
    localparam int MODE_W  = 3;
    localparam int MID_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT   = 3'd0,
        MODE_BYTE     = 3'd1,
        MODE_PP_FIFO  = 3'd2,
        MODE_ECP_FIFO = 3'd3,
        MODE_EPP      = 3'd4,
        MODE_RSVD     = 3'd5,
        MODE_FIFOTEST = 3'd6,
        MODE_CONFIG   = 3'd7
    } ecr_mode_e;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_CFGB = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    localparam logic [BYTE_W-1:0] UNMAPPED_READ = 8'hFF;

    // width field codes placed in bits 6:4 of the offset-0 configuration byte
    localparam logic [2:0] WCODE_16 = 3'd0;
    localparam logic [2:0] WCODE_8  = 3'd1;
    localparam logic [2:0] WCODE_32 = 3'd2;

    function automatic logic [BYTE_W-1:0] width_byte(input logic [2:0] code);
        return {1'b0, code, 4'b0000};
    endfunction

endpackage

// File: rtl/lpt_ecr_fifo.sv
module lpt_ecr_fifo #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW:0] DEPTH_W = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [PW-1:0]            rptr;
        logic                     empty;
        logic                     full;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [PW:0] wnext, rnext;

    always_comb begin
        st_d  = st_q;
        wnext = {1'b0, st_q.wptr} + 1'b1;
        rnext = {1'b0, st_q.rptr} + 1'b1;
        if (flush) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.empty = 1'b1;
            st_d.full  = 1'b0;
        end else if (push) begin
            st_d.mem[st_q.wptr] = din;
            if (wnext == DEPTH_W) begin
                st_d.wptr  = '0;
                st_d.full  = 1'b1;
                st_d.empty = 1'b0;
            end else begin
                st_d.wptr  = wnext[PW-1:0];
                st_d.full  = 1'b0;
                st_d.empty = 1'b0;
            end
        end else if (pop) begin
            if (rnext == DEPTH_W) st_d.rptr = '0;
            else                  st_d.rptr = rnext[PW-1:0];
            if (st_d.rptr == st_q.wptr) begin
                st_d.empty = 1'b1;
                st_d.full  = 1'b0;
            end else begin
                st_d.empty = 1'b0;
                st_d.full  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rptr];
    assign empty = st_q.empty;
    assign full  = st_q.full;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full)); // R3
    AST_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> !empty); // R4
    AST_POP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> !full); // R5

endmodule

// File: rtl/lpt_ecr_regs.sv
module lpt_ecr_regs
    import lpt_ecr_pkg::*;
#(
    parameter logic [2:0] CFGA_WCODE = WCODE_8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     addr,
    input  logic [BYTE_W-1:0]    wdata,
    output ecr_mode_e            mode,
    output logic [MID_W-1:0]     mid,
    output logic [BYTE_W-1:0]    cfga,
    output logic [BYTE_W-1:0]    cfgb,
    output logic                 flush_req,
    output logic                 push_req
);

    typedef struct packed {
        ecr_mode_e            mode;
        logic [MID_W-1:0]     mid;
        logic [BYTE_W-1:0]    cfga;
        logic [BYTE_W-1:0]    cfgb;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       test_mode;

    always_comb begin
        st_d      = st_q;
        test_mode = (st_q.mode == MODE_FIFOTEST);
        flush_req = 1'b0;
        push_req  = 1'b0;
        if (wr_en) begin
            unique case (addr)
                OFS_DATA: begin
                    if (test_mode) push_req = 1'b1;
                    else           st_d.cfga = wdata;
                end
                OFS_CFGB: st_d.cfgb = wdata;
                OFS_CTRL: begin
                    flush_req = (wdata[7:5] != st_q.mode);
                    st_d.mode = ecr_mode_e'(wdata[7:5]);
                    st_d.mid  = wdata[4:2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_COMPAT;
            st_q.mid  <= '0;
            st_q.cfga <= width_byte(CFGA_WCODE);
            st_q.cfgb <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign mid  = st_q.mid;
    assign cfga = st_q.cfga;
    assign cfgb = st_q.cfgb;

    AST_MODE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=> (mode == $past(wdata[7:5]))); // R2
    AST_CFGA_HELD_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA && mode == MODE_FIFOTEST) |=> $stable(cfga)); // R6

endmodule

// File: rtl/lpt_ecr_bank.sv
module lpt_ecr_bank
    import lpt_ecr_pkg::*;
#(
    parameter int         FIFO_DEPTH = 2,
    parameter logic [2:0] CFGA_WCODE = WCODE_8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        fifo_empty,
    output logic        fifo_full,
    output logic [2:0]  mode
);

    ecr_mode_e          cur_mode;
    logic [MID_W-1:0]   mid;
    logic [BYTE_W-1:0]  cfga, cfgb, fifo_dout;
    logic               flush_req, push_req, pop_req;
    logic               in_test;

    lpt_ecr_regs #(.CFGA_WCODE(CFGA_WCODE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .mode      (cur_mode),
        .mid       (mid),
        .cfga      (cfga),
        .cfgb      (cfgb),
        .flush_req (flush_req),
        .push_req  (push_req)
    );

    assign in_test = (cur_mode == MODE_FIFOTEST);
    assign pop_req = rd_en && !wr_en && (addr == OFS_DATA) && in_test;

    lpt_ecr_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_req),
        .push  (push_req),
        .pop   (pop_req),
        .din   (wdata),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        unique case (addr)
            OFS_DATA: rdata = in_test ? fifo_dout : cfga;
            OFS_CFGB: rdata = cfgb;
            OFS_CTRL: rdata = {cur_mode, mid, fifo_full, fifo_empty};
            default:  rdata = UNMAPPED_READ;
        endcase
    end

    assign mode = cur_mode;

    AST_SAME_MODE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && wdata[7:5] == mode)
        |=> ($stable(fifo_empty) && $stable(fifo_full))); // R3
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > OFS_CTRL)
        |=> ($stable(mode) && $stable(cfgb) && $stable(cfga) && $stable(fifo_empty))); // R8
    AST_CFGB_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CFGB) |=> (cfgb == $past(wdata))); // R7

endmodule

// File: tb/lpt_ecr_bank_test.sv
module lpt_ecr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       fifo_empty, fifo_full;
    logic [2:0] mode;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // bench-side model
    bit [2:0] m_mode;
    bit [2:0] m_mid;
    bit [7:0] m_cfga, m_cfgb;
    bit [7:0] m_mem [DEPTH];
    int       m_wp, m_rp;
    bit       m_emp, m_ful;

    lpt_ecr_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .mode(mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_read(input bit [2:0] a);
        case (a)
            3'd0: return (m_mode == 3'd6) ? m_mem[m_rp] : m_cfga;
            3'd1: return m_cfgb;
            3'd2: return {m_mode, m_mid, m_ful, m_emp};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check_flags(input string tag);
        chk({tag, " empty pin (R9)"}, int'(fifo_empty), int'(m_emp));
        chk({tag, " full pin (R9)"}, int'(fifo_full), int'(m_ful));
    endtask

    task automatic do_wr(input bit [2:0] a, input bit [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (a)
            3'd0: if (m_mode == 3'd6) begin
                m_mem[m_wp] = d;
                m_wp++;
                if (m_wp == DEPTH) begin m_wp = 0; m_ful = 1; m_emp = 0; end
                else begin m_ful = 0; m_emp = 0; end
            end else m_cfga = d;
            3'd1: m_cfgb = d;
            3'd2: begin
                if (d[7:5] != m_mode) begin m_wp = 0; m_rp = 0; m_emp = 1; m_ful = 0; end
                m_mode = d[7:5];
                m_mid  = d[4:2];
            end
            default: ;
        endcase
        check_flags(tag);
    endtask

    task automatic do_rd(input bit [2:0] a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        chk(tag, int'(rdata), int'(exp_read(a)));
        @(posedge clk); #1;
        rd_en = 1'b0;
        if (a == 3'd0 && m_mode == 3'd6) begin
            m_rp = (m_rp + 1) % DEPTH;
            if (m_rp == m_wp) begin m_emp = 1; m_ful = 0; end
            else begin m_emp = 0; m_ful = 0; end
        end
        check_flags(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                miscompares++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        bit [7:0] d;
        m_mode = 0; m_mid = 0; m_cfga = 8'h10; m_cfgb = 0;
        m_wp = 0; m_rp = 0; m_emp = 1; m_ful = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        do_rd(3'd2, "R1 ctrl reset");
        chk("R1 ctrl reset literal", int'(exp_read(3'd2)), 8'h01);
        do_rd(3'd0, "R1 cfgA reset (R6 width code 1)");
        do_rd(3'd1, "R1 cfgB reset");

        // R8 unmapped offsets
        for (int a = 3; a < 8; a++) begin
            do_wr(3'(a), 8'hA5, "R8 unmapped write");
            do_rd(3'(a), "R8 unmapped read");
        end
        do_rd(3'd1, "R8 cfgB after unmapped writes");
        do_rd(3'd2, "R8 ctrl after unmapped writes");

        // R7 config B
        do_wr(3'd1, 8'h3C, "R7 cfgB write");
        do_rd(3'd1, "R7 cfgB readback");

        // R6 plain offset-0 register outside test mode
        do_wr(3'd0, 8'h5A, "R6 cfgA write");
        do_rd(3'd0, "R6 cfgA readback");
        do_rd(3'd2, "R6 FIFO untouched");

        // R2 mode sweep, low bits read-only
        for (int mcode = 0; mcode < 8; mcode++) begin
            do_wr(3'd2, {3'(mcode), 5'b10111}, "R2 mode write");
            do_rd(3'd2, "R2 mode readback");
            chk("R2 mode pin", int'(mode), mcode);
        end
        do_wr(3'd2, 8'h20, "R2 replace not OR");
        do_rd(3'd2, "R2 replace readback");

        // R4 / R5 fill and drain in test mode
        do_wr(3'd2, 8'hC0, "R3 enter test mode");
        do_rd(3'd2, "R3 flush on mode change");
        do_wr(3'd0, 8'hA1, "R4 first push");
        do_rd(3'd2, "R4 some-data flags");
        do_wr(3'd0, 8'hB2, "R4 second push full");
        do_rd(3'd2, "R4 full flags");
        do_wr(3'd2, 8'hDC, "R3 same mode no flush");
        do_rd(3'd2, "R3 flags held");
        do_rd(3'd0, "R5 pop first");
        do_rd(3'd0, "R5 pop second");
        do_rd(3'd2, "R5 empty after drain");
        // R10 push past full
        do_wr(3'd0, 8'h11, "R10 push a");
        do_wr(3'd0, 8'h22, "R10 push b");
        do_wr(3'd0, 8'h33, "R10 overwrite");
        do_rd(3'd2, "R10 flags after overwrite");
        do_rd(3'd0, "R10 pop overwritten slot");
        // R3 flush with data buffered
        do_wr(3'd2, 8'h00, "R3 leave test mode");
        do_rd(3'd2, "R3 flushed");
        do_wr(3'd2, 8'hC0, "R3 reenter");

        // pseudo-random sweep
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom % 16;
            d = 8'($urandom);
            if (sel < 5)       do_wr(3'd0, d, "R4 rand push");
            else if (sel < 10) do_rd(3'd0, "R5 rand pop");
            else if (sel == 10) do_wr(3'd2, ($urandom % 4 != 0) ? {3'd6, d[4:0]} : d, "R3 rand ctrl");
            else if (sel == 11) do_rd(3'd2, "R2 rand ctrl read");
            else if (sel == 12) do_wr(3'd1, d, "R7 rand cfgB");
            else if (sel == 13) do_rd(3'd1, "R7 rand cfgB read");
            else if (sel == 14) do_wr(3'(3 + $urandom % 5), d, "R8 rand unmapped");
            else                do_rd(3'(3 + $urandom % 5), "R8 rand unmapped read");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule